// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround SRAM Core

This block is a synchronous single-port memory. Each word is 36 bits wide and is split into four 9-bit byte lanes. Every control input is sampled on the rising clock edge. An active-low clock enable freezes all internal state when it is high.

Read data comes straight out of the storage array in the cycle after the address edge; there is no output register. Write data comes one clock after its address. Even so, reads, writes and deselects can be issued back to back on every clock without idle cycles. To allow this, each captured write is held in a one-entry pending stage, and reads of that address are served from it. The output drivers switch off on their own in write-data cycles.

A load command places a full address in the core. Continue commands then step through a four-word burst, in either linear or interleaved order. The shared data bus is split into separate input, output and output-drive ports.

Top module: `ft_sram_core`

## Requirements
- R1: After reset, the output drive is off and every word of the array reads as zero.
- R2: A read loaded at an enabled edge (`load_n` low, all three selects active, `wr_n` high) presents that word on `d_out` during the next cycle, with `d_oe` high when `out_en_n` is low.
- R3: For a write loaded at one enabled edge, the data and byte selects are sampled at the next enabled edge. A later read of that address returns the written word.
- R4: `bsel_n[i]` low enables lane i, which is `d_in[9*i+8:9*i]`. A lane whose select is high keeps its previous contents.
- R5: A read loaded on the same edge that captures a write's data, to the same address, returns the new lanes merged with the old contents of the unselected lanes.
- R6: In the data cycle of a write, `d_oe` is low whatever the level of `out_en_n`.
- R7: A load edge with any select inactive leaves `d_oe` low in the next cycle. A continue command issued while deselected keeps the core deselected.
- R8: While `out_en_n` is high, `d_oe` is low. This path is combinational and leaves `d_out` unchanged.
- R9: While `clk_en_n` is high, edges are ignored. The current access, the burst position and the pending write all hold, so `d_out` and `d_oe` stay the same.
- R10: With `burst_ilv` low at load, continue commands step the two low address bits as (base + n) mod 4, wrapping after the fourth beat.
- R11: With `burst_ilv` high at load, the low two address bits follow base XOR n.
- R12: In a burst write, continue beats ignore the selects and `wr_n`, and sample the byte selects again on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Low: this edge is acted on; high: edge ignored |
| en_a_n | input | 1 | Select, active low |
| en_b | input | 1 | Select, active high |
| en_c_n | input | 1 | Select, active low |
| load_n | input | 1 | Low: load new address; high: continue burst |
| wr_n | input | 1 | Low at load: write access; high: read |
| bsel_n | input | 4 | Per-lane write enables, active low, sampled with write data |
| addr | input | 8 | Word address |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | 36 | Write data (inbound half of the shared bus) |
| d_out | output | 36 | Read data (outbound half of the shared bus) |
| d_oe | output | 1 | High when the core drives the bus |

## Verification
The bench targets the edge where a write's data is captured and, on that same edge, a read of the same address is loaded. A core without working bypass would return the stale word; a core that ignored the mask would wipe the unselected lanes. It checks that a held clock enable does not capture a pending write's data, since a core that advanced would write the wrong value. It walks burst order and wrap in both modes. It also runs a burst write whose continue beats carry inactive selects and a read-level `wr_n`: a core that decoded those beats as new commands would drop the burst or turn it into reads.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_t;
endpackage

// File: rtl/ft_cmd_ctrl.sv
module ft_cmd_ctrl
  import ftsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              load_n,
  input  logic              sel_ok,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_ilv,
  output acc_t              acc_kind,
  output logic [ADDR_W-1:0] cur_addr
);
  acc_t                kind_q, kind_d;
  logic [ADDR_W-1:0]   base_q, base_d;
  logic [BURST_W-1:0]  cnt_q, cnt_d;
  logic                ilv_q, ilv_d;
  logic [BURST_W-1:0]  lo;

  always_comb begin
    kind_d = kind_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    ilv_d  = ilv_q;
    if (!clk_en_n) begin
      if (!load_n) begin
        if (sel_ok) begin
          kind_d = wr_n ? ACC_READ : ACC_WRITE;
          base_d = addr;
          cnt_d  = '0;
          ilv_d  = burst_ilv;
        end else begin
          kind_d = ACC_NONE;
        end
      end else if (kind_q != ACC_NONE) begin
        cnt_d = cnt_q + BURST_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= ACC_NONE;
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else begin
      kind_q <= kind_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      ilv_q  <= ilv_d;
    end
  end

  assign lo       = ilv_q ? (base_q[BURST_W-1:0] ^ cnt_q) : (base_q[BURST_W-1:0] + cnt_q);
  assign cur_addr = {base_q[ADDR_W-1:BURST_W], lo};
  assign acc_kind = kind_q;

  // R9: a held clock enable freezes the access and burst position
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(kind_q) && $stable(cur_addr)));

  // R10: linear continue advances the low bits by one, modulo the burst
  a_r10_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n && kind_q != ACC_NONE && !ilv_q)
      |=> (cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + BURST_W'(1)));

  // R12 / R7: continue never changes the access kind
  a_r12_cont_keeps_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && load_n) |=> (kind_q == $past(kind_q)));
endmodule

// File: rtl/ft_wr_stage.sv
module ft_wr_stage #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  bsel_n,
  output logic              pw_valid,
  output logic [ADDR_W-1:0] pw_addr,
  output logic [DATA_W-1:0] pw_data,
  output logic [LANES-1:0]  pw_mask,
  output logic              commit
);
  logic              v_d;
  logic [ADDR_W-1:0] a_d;
  logic [DATA_W-1:0] d_d;
  logic [LANES-1:0]  m_d;

  always_comb begin
    v_d = pw_valid;
    a_d = pw_addr;
    d_d = pw_data;
    m_d = pw_mask;
    if (cap) begin
      v_d = 1'b1;
      a_d = addr;
      d_d = din;
      m_d = ~bsel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_valid <= 1'b0;
      pw_addr  <= '0;
      pw_data  <= '0;
      pw_mask  <= '0;
    end else begin
      pw_valid <= v_d;
      pw_addr  <= a_d;
      pw_data  <= d_d;
      pw_mask  <= m_d;
    end
  end

  // the older pending entry retires to the array when a newer one arrives
  assign commit = cap && pw_valid;

  // R3: pending entry changes only on a write-data capture
  a_r3_pending_only_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(pw_valid) && $stable(pw_addr) && $stable(pw_data)));
endmodule

// File: rtl/ft_store.sv
module ft_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wmask,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && wmask[g]) begin
        mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/ft_sram_core.sv
module ft_sram_core
  import ftsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              en_c_n,
  input  logic              load_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_ilv,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] d_in,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe
);
  logic [1:0]        rs_q;
  logic              rst_i;
  logic              sel_ok;
  acc_t              acc_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic              cap;
  logic              pw_valid, commit;
  logic [ADDR_W-1:0] pw_addr;
  logic [DATA_W-1:0] pw_data, arr_rd;
  logic [LANES-1:0]  pw_mask;
  logic              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign sel_ok = !en_a_n && en_b && !en_c_n;

  ft_cmd_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_ctrl (
    .clk(clk), .rst_n(rst_i), .clk_en_n(clk_en_n), .load_n(load_n),
    .sel_ok(sel_ok), .wr_n(wr_n), .addr(addr), .burst_ilv(burst_ilv),
    .acc_kind(acc_kind), .cur_addr(cur_addr)
  );

  assign cap = !clk_en_n && (acc_kind == ACC_WRITE);

  ft_wr_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_wst (
    .clk(clk), .rst_n(rst_i), .cap(cap), .addr(cur_addr), .din(d_in),
    .bsel_n(bsel_n), .pw_valid(pw_valid), .pw_addr(pw_addr),
    .pw_data(pw_data), .pw_mask(pw_mask), .commit(commit)
  );

  ft_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_store (
    .clk(clk), .rst_n(rst_i), .we(commit), .waddr(pw_addr), .wdata(pw_data),
    .wmask(pw_mask), .raddr(cur_addr), .rdata(arr_rd)
  );

  // coherency: lanes held in the pending entry override the array
  assign hit = pw_valid && (pw_addr == cur_addr);
  for (genvar g = 0; g < LANES; g++) begin : g_byp
    assign d_out[g*LANE_W +: LANE_W] = (hit && pw_mask[g]) ? pw_data[g*LANE_W +: LANE_W]
                                                           : arr_rd[g*LANE_W +: LANE_W];
  end

  assign d_oe = (acc_kind == ACC_READ) && !out_en_n;

  // R6: the cycle after a write load is a data cycle, drivers off
  a_r6_write_data_no_drive: assert property (@(posedge clk) disable iff (!rst_i)
    (!clk_en_n && !load_n && sel_ok && !wr_n) |=> !d_oe);

  // R7: deselecting load turns drivers off for the next cycle
  a_r7_deselect_off: assert property (@(posedge clk) disable iff (!rst_i)
    (!clk_en_n && !load_n && !sel_ok) |=> !d_oe);

  // R9: read data unchanged across a stalled edge
  a_r9_stall_data: assert property (@(posedge clk) disable iff (!rst_i)
    clk_en_n |=> ($stable(d_out) && ((d_oe == $past(d_oe)) || (out_en_n != $past(out_en_n)))));
endmodule

// File: tb/test_ft_sram_core.sv
module test_ft_sram_core;
  logic        clk = 1'b0;
  logic        rst_n, clk_en_n, en_a_n, en_b, en_c_n, load_n, wr_n, burst_ilv, out_en_n;
  logic [3:0]  bsel_n;
  logic [7:0]  addr;
  logic [35:0] d_in, d_out;
  logic        d_oe;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  localparam logic [2:0]  ALL = 3'b111;
  localparam logic [35:0] X = 36'h123456789, Y = 36'hABCDEF012, Z = 36'hFFFFFFFFF;
  localparam logic [35:0] W = 36'h0C0FFEE11;

  always #2 clk = ~clk;

  ft_sram_core i_ft_sram_core (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .en_a_n(en_a_n), .en_b(en_b),
    .en_c_n(en_c_n), .load_n(load_n), .wr_n(wr_n), .bsel_n(bsel_n), .addr(addr),
    .burst_ilv(burst_ilv), .out_en_n(out_en_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] bs);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (!bs[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [35:0] fw(logic [7:0] a);
    return {28'h5A5A5A5, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(input logic cen, input logic ld, input logic [2:0] act, input logic w,
                      input logic [7:0] a, input logic [3:0] bs, input logic [35:0] dd);
    clk_en_n = cen; load_n = ld; en_a_n = ~act[0]; en_b = act[1]; en_c_n = ~act[2];
    wr_n = w; addr = a; bsel_n = bs; d_in = dd;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [3:0] bs, input logic [35:0] dd);
    step(1'b0, 1'b0, ALL, 1'b1, a, bs, dd);
  endtask
  task automatic do_write(input logic [7:0] a, input logic [3:0] bs, input logic [35:0] dd);
    step(1'b0, 1'b0, ALL, 1'b0, a, bs, dd);
  endtask
  task automatic do_cont(input logic [3:0] bs, input logic [35:0] dd);
    step(1'b0, 1'b1, ALL, 1'b1, 8'h00, bs, dd);
  endtask

  task automatic t_reset;
    chk("R1", "oe after reset", {35'd0, d_oe}, 36'd0);
    do_read(8'h05, 4'h0, '0);
    chk("R1", "array zero", d_out, 36'd0);
    chk("R2", "read drives", {35'd0, d_oe}, 36'd1);
  endtask

  task automatic t_write_read;
    do_write(8'd10, 4'h0, '0);
    chk("R6", "write data cycle off", {35'd0, d_oe}, 36'd0);
    do_read(8'd10, 4'h0, X);
    chk("R5", "same-edge read full", d_out, X);
    do_write(8'd11, 4'h0, '0);
    do_read(8'd10, 4'h0, Y);
    chk("R3", "committed word", d_out, X);
    do_read(8'd11, 4'h0, '0);
    chk("R3", "second word", d_out, Y);
    chk("R2", "read drive", {35'd0, d_oe}, 36'd1);
  endtask

  task automatic t_lanes;
    do_write(8'd10, 4'h0, '0);
    do_read(8'd10, 4'b1010, Z);
    chk("R5", "merged bypass", d_out, merge(X, Z, 4'b1010));
    do_write(8'd12, 4'h0, '0);
    do_read(8'd10, 4'h0, '0);
    chk("R4", "lane mask in array", d_out, merge(X, Z, 4'b1010));
    do_read(8'd12, 4'h0, '0);
    chk("R4", "full-mask zero write", d_out, 36'd0);
  endtask

  task automatic t_oe;
    do_read(8'd11, 4'h0, '0);
    out_en_n = 1'b1; #1;
    chk("R8", "oe high turns off", {35'd0, d_oe}, 36'd0);
    chk("R8", "data unchanged", d_out, Y);
    out_en_n = 1'b0; #1;
    chk("R8", "oe low drives again", {35'd0, d_oe}, 36'd1);
  endtask

  task automatic t_deselect;
    for (int k = 0; k < 3; k++) begin
      do_read(8'd11, 4'h0, '0);
      step(1'b0, 1'b0, ALL & ~(3'b001 << k), 1'b1, 8'd11, 4'h0, '0);
      chk("R7", $sformatf("select %0d inactive", k), {35'd0, d_oe}, 36'd0);
    end
    do_cont(4'h0, '0);
    chk("R7", "continue while deselected", {35'd0, d_oe}, 36'd0);
  endtask

  task automatic t_stall;
    do_read(8'd11, 4'h0, '0);
    step(1'b1, 1'b0, ALL, 1'b1, 8'd10, 4'h0, '0);
    chk("R9", "stalled data", d_out, Y);
    chk("R9", "stalled drive", {35'd0, d_oe}, 36'd1);
    do_write(8'd20, 4'h0, '0);
    step(1'b1, 1'b0, ALL, 1'b1, 8'd10, 4'h0, 36'hDEADBEEF0);
    chk("R9", "still data cycle", {35'd0, d_oe}, 36'd0);
    do_read(8'd20, 4'h0, W);
    chk("R9", "data after stall", d_out, W);
  endtask

  task automatic t_linear;
    burst_ilv = 1'b0;
    do_write(8'h40, 4'h0, '0);
    do_write(8'h41, 4'h0, fw(8'h40));
    do_write(8'h42, 4'h0, fw(8'h41));
    do_write(8'h43, 4'h0, fw(8'h42));
    do_read(8'h42, 4'h0, fw(8'h43));
    chk("R10", "beat0", d_out, fw(8'h42));
    do_cont(4'h0, '0); chk("R10", "beat1", d_out, fw(8'h43));
    do_cont(4'h0, '0); chk("R10", "beat2 wrap", d_out, fw(8'h40));
    do_cont(4'h0, '0); chk("R10", "beat3", d_out, fw(8'h41));
    do_cont(4'h0, '0); chk("R10", "wrap to base", d_out, fw(8'h42));
  endtask

  task automatic t_interleave;
    burst_ilv = 1'b1;
    do_read(8'h41, 4'h0, '0);
    chk("R11", "beat0", d_out, fw(8'h41));
    do_cont(4'h0, '0); chk("R11", "beat1", d_out, fw(8'h40));
    burst_ilv = 1'b0;
    do_cont(4'h0, '0); chk("R11", "beat2", d_out, fw(8'h43));
    do_cont(4'h0, '0); chk("R11", "beat3", d_out, fw(8'h42));
  endtask

  task automatic t_burst_write;
    burst_ilv = 1'b0;
    do_write(8'h80, 4'h0, '0);
    step(1'b0, 1'b1, 3'b000, 1'b1, 8'h00, 4'h0, 36'h111111111);
    chk("R12", "beat still write", {35'd0, d_oe}, 36'd0);
    step(1'b0, 1'b1, 3'b000, 1'b1, 8'h00, 4'h0, 36'h222222222);
    step(1'b0, 1'b1, 3'b000, 1'b1, 8'h00, 4'b0111, 36'h3FFFFFFFF);
    do_read(8'h80, 4'h0, 36'h444444444);
    chk("R12", "beat0", d_out, 36'h111111111);
    do_cont(4'h0, '0); chk("R12", "beat1", d_out, 36'h222222222);
    do_cont(4'h0, '0); chk("R12", "beat2 lane3 only", d_out, merge(36'd0, 36'h3FFFFFFFF, 4'b0111));
    do_cont(4'h0, '0); chk("R12", "beat3", d_out, 36'h444444444);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; en_a_n = 1'b1; en_b = 1'b0; en_c_n = 1'b1;
    load_n = 1'b0; wr_n = 1'b1; bsel_n = 4'hF; addr = '0; burst_ilv = 1'b0;
    out_en_n = 1'b0; d_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_lanes();
    t_oe();
    t_deselect();
    t_stall();
    t_linear();
    t_interleave();
    t_burst_write();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule